// File: doc/BRIEF.md
# Split-Transaction Bus Tagged Master

This block issues read and write transactions onto a system bus whose address bus and data bus are separate and are held independently. Each accepted request is given a small tag. The address phase for the request then goes out on the address bus with that tag. The master does not wait for data before it issues the next address phase. Up to one transaction per tag can be in flight at once.

Targets answer with different and changing latencies, so data phases come back in any order. Each data phase carries the tag of the transaction it finishes. The block matches the tag to the open transaction and reports a completion with the same tag and the read/write kind of the original request. It then returns the tag to the pool of free tags. A data phase whose tag has no open address phase raises a one-cycle error flag and changes nothing else.

The requester sees a valid/ready handshake on the request side. The address bus uses a valid/ready handshake of one cycle per transaction. The data bus is a plain valid strobe with tag and data.

Top module: `split_txn_master`

## Requirements
- R1: After reset `abus_valid`, `cpl_valid` and `err_bad_tag` are low, no tag is in use, and `req_ready` is high.
- R2: `req_ready` is high exactly when at least one tag is free and the address register is either empty or handing off in this cycle (`abus_valid` and `abus_ready` both high). A request taken while `req_valid` and `req_ready` are both high appears on the address bus in the next cycle, with its address and its write flag (1 = write, 0 = read).
- R3: An accepted request receives the lowest-numbered free tag, counting from tag 0 up to tag 2^ID_W-1.
- R4: While `abus_valid` is high and `abus_ready` is low, `abus_valid`, `abus_tag`, `abus_addr` and `abus_write` keep their values into the next cycle.
- R5: When every tag is in use, `req_ready` stays low. New address phases are issued while earlier transactions still wait for data.
- R6: A data phase (`dbus_valid` high) that carries a tag whose address handshake happened in an earlier cycle produces `cpl_valid` in the next cycle. That completion carries the same tag, the data, and the write flag of the original request, whatever the order of issue.
- R7: The tag of a completed transaction is free from the cycle after the data phase, and the next accepted request can take it.
- R8: A data phase whose tag is not in use, or whose address handshake has not yet happened, raises `err_bad_tag` for one cycle in the next cycle. It gives no completion and leaves the state of every tag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester offers a transaction |
| req_ready | output | 1 | Transaction can be taken this cycle |
| req_addr | input | ADDR_W | Transaction address |
| req_write | input | 1 | 1 = write, 0 = read |
| abus_valid | output | 1 | Address phase valid |
| abus_ready | input | 1 | Address bus accepts the phase |
| abus_tag | output | ID_W | Tag of the address phase |
| abus_addr | output | ADDR_W | Address of the address phase |
| abus_write | output | 1 | Write flag of the address phase |
| dbus_valid | input | 1 | Data phase present |
| dbus_tag | input | ID_W | Tag carried by the data phase |
| dbus_data | input | DATA_W | Data of the data phase |
| cpl_valid | output | 1 | Completion strobe |
| cpl_tag | output | ID_W | Tag of the completed transaction |
| cpl_write | output | 1 | Write flag of the completed transaction |
| cpl_data | output | DATA_W | Data returned by the data phase |
| err_bad_tag | output | 1 | Data phase carried a tag with no open address phase |

## Verification
The bench builds the block with ID_W = 3, so eight tags, and with 16-bit address and data. With eight tags, full occupancy and the stall it causes are reached within a few requests. Reuse of a freed tag happens many times over a few thousand random cycles. A simulated target gives each issued transaction its own random latency and picks among the ready ones at random, so completions run well out of issue order. Directed steps cover a stalled address bus, a data phase that arrives before its own address handshake, tags not in use, and the reuse of a tag in the middle of the range.

// File: rtl/stm_pkg.sv
package stm_pkg;

  localparam int unsigned STM_DEF_ID_W   = 3;
  localparam int unsigned STM_DEF_ADDR_W = 32;
  localparam int unsigned STM_DEF_DATA_W = 32;

  typedef enum logic {
    STM_RD = 1'b0,
    STM_WR = 1'b1
  } stm_op_e;

endpackage

// File: rtl/stm_tag_pool.sv
module stm_tag_pool #(
  parameter int unsigned ID_W = stm_pkg::STM_DEF_ID_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc_en,
  output logic [ID_W-1:0]         alloc_tag,
  output logic                    any_free,
  input  logic                    issue_en,
  input  logic [ID_W-1:0]         issue_tag,
  input  logic                    done_en,
  input  logic [ID_W-1:0]         done_tag,
  output logic [(1<<ID_W)-1:0]    issued_vec
);
  localparam int unsigned NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] inuse_q;
  logic [NUM_IDS-1:0] issued_q;

  // lowest free tag wins
  always_comb begin
    any_free  = 1'b0;
    alloc_tag = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (!inuse_q[i]) begin
        any_free  = 1'b1;
        alloc_tag = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inuse_q  <= '0;
      issued_q <= '0;
    end else begin
      if (done_en) begin
        inuse_q[done_tag]  <= 1'b0;
        issued_q[done_tag] <= 1'b0;
      end
      if (issue_en) issued_q[issue_tag] <= 1'b1;
      if (alloc_en) inuse_q[alloc_tag]  <= 1'b1;
    end
  end

  assign issued_vec = issued_q;

  // R3: a granted tag was not already in use
  a_r3_grant_was_free: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (any_free && !inuse_q[alloc_tag]));

  // R5: a full pool never grants
  a_r5_full_no_grant: assert property (@(posedge clk) disable iff (rst)
    (&inuse_q) |-> !alloc_en);

  // R7: a finished tag is free in the following cycle
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    done_en |=> !inuse_q[$past(done_tag)]);

  // R8: a tag is only issued once and only after allocation
  a_r8_issue_legal: assert property (@(posedge clk) disable iff (rst)
    issue_en |-> (inuse_q[issue_tag] && !issued_q[issue_tag]));

endmodule

// File: rtl/stm_addr_stage.sv
module stm_addr_stage #(
  parameter int unsigned ID_W   = stm_pkg::STM_DEF_ID_W,
  parameter int unsigned ADDR_W = stm_pkg::STM_DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ID_W-1:0]   load_tag,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_write,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_tag,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write
);
  logic valid_q;

  assign can_load  = !valid_q || out_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      out_tag   <= '0;
      out_addr  <= '0;
      out_write <= 1'b0;
    end else if (load_en) begin
      valid_q   <= 1'b1;
      out_tag   <= load_tag;
      out_addr  <= load_addr;
      out_write <= load_write;
    end else if (out_ready) begin
      valid_q   <= 1'b0;
    end
  end

  // R4: a stalled address phase holds still
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready) |=> (valid_q && $stable(out_tag) &&
                                 $stable(out_addr) && $stable(out_write)));

  // R2: loading is only done when the register is free or draining
  a_r2_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (!valid_q || out_ready));

endmodule

// File: rtl/stm_kind_table.sv
module stm_kind_table #(
  parameter int unsigned ID_W = stm_pkg::STM_DEF_ID_W
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ID_W-1:0]     wr_tag,
  input  stm_pkg::stm_op_e    wr_op,
  input  logic [ID_W-1:0]     rd_tag,
  output stm_pkg::stm_op_e    rd_op
);
  localparam int unsigned DEPTH = 1 << ID_W;

  stm_pkg::stm_op_e mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_tag] <= wr_op;
  end

  assign rd_op = mem[rd_tag];

endmodule

// File: rtl/split_txn_master.sv
module split_txn_master #(
  parameter int unsigned ID_W   = stm_pkg::STM_DEF_ID_W,
  parameter int unsigned ADDR_W = stm_pkg::STM_DEF_ADDR_W,
  parameter int unsigned DATA_W = stm_pkg::STM_DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              abus_valid,
  input  logic              abus_ready,
  output logic [ID_W-1:0]   abus_tag,
  output logic [ADDR_W-1:0] abus_addr,
  output logic              abus_write,
  input  logic              dbus_valid,
  input  logic [ID_W-1:0]   dbus_tag,
  input  logic [DATA_W-1:0] dbus_data,
  output logic              cpl_valid,
  output logic [ID_W-1:0]   cpl_tag,
  output logic              cpl_write,
  output logic [DATA_W-1:0] cpl_data,
  output logic              err_bad_tag
);
  import stm_pkg::*;

  localparam int unsigned NUM_IDS = 1 << ID_W;

  logic               any_free;
  logic [ID_W-1:0]    grant_tag;
  logic               can_load;
  logic               accept;
  logic               issue_en;
  logic               hit;
  logic [NUM_IDS-1:0] issued_vec;
  stm_op_e            done_op;

  assign req_ready = any_free && can_load;
  assign accept    = req_valid && req_ready;
  assign issue_en  = abus_valid && abus_ready;
  assign hit       = dbus_valid && issued_vec[dbus_tag];

  stm_tag_pool #(.ID_W(ID_W)) u_pool (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (accept),
    .alloc_tag  (grant_tag),
    .any_free   (any_free),
    .issue_en   (issue_en),
    .issue_tag  (abus_tag),
    .done_en    (hit),
    .done_tag   (dbus_tag),
    .issued_vec (issued_vec)
  );

  stm_addr_stage #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_astage (
    .clk        (clk),
    .rst        (rst),
    .load_en    (accept),
    .load_tag   (grant_tag),
    .load_addr  (req_addr),
    .load_write (req_write),
    .can_load   (can_load),
    .out_valid  (abus_valid),
    .out_ready  (abus_ready),
    .out_tag    (abus_tag),
    .out_addr   (abus_addr),
    .out_write  (abus_write)
  );

  stm_kind_table #(.ID_W(ID_W)) u_kind (
    .clk    (clk),
    .wr_en  (accept),
    .wr_tag (grant_tag),
    .wr_op  (req_write ? STM_WR : STM_RD),
    .rd_tag (dbus_tag),
    .rd_op  (done_op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_valid   <= 1'b0;
      cpl_tag     <= '0;
      cpl_write   <= 1'b0;
      cpl_data    <= '0;
      err_bad_tag <= 1'b0;
    end else begin
      cpl_valid   <= hit;
      err_bad_tag <= dbus_valid && !hit;
      if (hit) begin
        cpl_tag   <= dbus_tag;
        cpl_write <= (done_op == STM_WR);
        cpl_data  <= dbus_data;
      end
    end
  end

  // R2: an accepted request is on the address bus next cycle
  a_r2_accept_issues: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> abus_valid);

  // R6: a completion always follows a data phase
  a_r6_cpl_from_data: assert property (@(posedge clk) disable iff (rst)
    cpl_valid |-> $past(dbus_valid));

  // R8: error and completion never coincide
  a_r8_err_excl: assert property (@(posedge clk) disable iff (rst)
    err_bad_tag |-> (!cpl_valid && $past(dbus_valid)));

endmodule

// File: tb/test_split_txn_master.sv
module test_split_txn_master;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 3;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NT = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, abus_ready = 1'b0, dbus_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IW-1:0] dbus_tag = '0;
  logic [DW-1:0] dbus_data = '0;
  logic req_ready, abus_valid, abus_write, cpl_valid, cpl_write, err_bad_tag;
  logic [IW-1:0] abus_tag, cpl_tag;
  logic [AW-1:0] abus_addr;
  logic [DW-1:0] cpl_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_txn_master #(.ID_W(IW), .ADDR_W(AW), .DATA_W(DW)) i_split_txn_master (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .abus_valid(abus_valid), .abus_ready(abus_ready), .abus_tag(abus_tag),
    .abus_addr(abus_addr), .abus_write(abus_write),
    .dbus_valid(dbus_valid), .dbus_tag(dbus_tag), .dbus_data(dbus_data),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_write(cpl_write), .cpl_data(cpl_data),
    .err_bad_tag(err_bad_tag)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  bit m_inuse [NT];
  bit m_iss   [NT];
  bit m_wr    [NT];
  int t_cnt   [NT];
  bit e_av = 0, e_aw = 0, e_cv = 0, e_cw = 0, e_err = 0;
  logic [IW-1:0] e_at = '0, e_ct = '0;
  logic [AW-1:0] e_aa = '0;
  logic [DW-1:0] e_cd = '0;
  bit stalled = 0;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NT; i++) if (!m_inuse[i]) return i;
    return -1;
  endfunction

  // called just after a negedge; drives, predicts, then checks at next negedge
  task automatic step(bit rv, bit rw, logic [AW-1:0] ra, bit ar,
                      bit dv, logic [IW-1:0] dt, logic [DW-1:0] dd);
    int lf;
    bit exp_rdy, hit;
    req_valid = rv; req_write = rw; req_addr = ra; abus_ready = ar;
    dbus_valid = dv; dbus_tag = dt; dbus_data = dd;
    #1;
    lf = lowest_free();
    exp_rdy = (lf >= 0) && (!e_av || ar);
    chk(req_ready == exp_rdy, (lf < 0) ? "R5" : "R2", req_ready, exp_rdy);
    hit = dv && m_iss[dt];
    e_cv = hit; e_err = dv && !hit;
    if (hit) begin
      e_ct = dt; e_cd = dd; e_cw = m_wr[dt];
      m_inuse[dt] = 0; m_iss[dt] = 0;
    end
    stalled = e_av && !ar;
    if (e_av && ar) begin
      m_iss[e_at] = 1; t_cnt[e_at] = $urandom_range(0, 12); e_av = 0;
    end
    if (rv && exp_rdy) begin
      m_inuse[lf] = 1; m_wr[lf] = rw;
      e_av = 1; e_at = IW'(lf); e_aa = ra; e_aw = rw;
    end
    @(negedge clk);
    chk(abus_valid == e_av, stalled ? "R4" : "R2", abus_valid, e_av);
    if (e_av) begin
      chk(abus_tag == e_at, stalled ? "R4" : "R3", abus_tag, e_at);
      chk(abus_addr == e_aa, stalled ? "R4" : "R2", abus_addr, e_aa);
      chk(abus_write == e_aw, stalled ? "R4" : "R2", abus_write, e_aw);
    end
    chk(cpl_valid == e_cv, "R6", cpl_valid, e_cv);
    if (e_cv) begin
      chk(cpl_tag == e_ct, "R6", cpl_tag, e_ct);
      chk(cpl_data == e_cd, "R6", cpl_data, e_cd);
      chk(cpl_write == e_cw, "R6", cpl_write, e_cw);
    end
    chk(err_bad_tag == e_err, "R8", err_bad_tag, e_err);
  endtask

  initial begin
    int ready_list [NT];
    int nr, pick;
    void'($urandom(32'd4711));
    for (int i = 0; i < NT; i++) begin m_inuse[i] = 0; m_iss[i] = 0; m_wr[i] = 0; t_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(abus_valid == 0, "R1", abus_valid, 0);
    chk(cpl_valid == 0, "R1", cpl_valid, 0);
    chk(err_bad_tag == 0, "R1", err_bad_tag, 0);
    #1 chk(req_ready == 1, "R1", req_ready, 1);

    // R2/R4/R8: stalled address bus; data for a tag not yet handed off
    step(1, 1, 16'h1000, 0, 0, 0, 0);
    step(1, 0, 16'h2000, 0, 1, 0, 16'hdead);
    step(0, 0, 16'h0, 0, 0, 0, 0);
    // R5: fill all tags, address bus always ready
    for (int i = 0; i < NT; i++) step(1, i[0], AW'(16'h3000 + i), 1, 0, 0, 0);
    step(1, 0, 16'h4000, 1, 0, 0, 0);
    chk(m_inuse[NT-1] == 1, "R5", m_inuse[NT-1], 1);
    // R7: complete tag 5 then the next request takes tag 5
    step(0, 0, 16'h0, 1, 1, 3'd5, 16'h5555);
    step(1, 1, 16'h5abc, 1, 0, 0, 0);
    chk(abus_valid && abus_tag == 3'd5, "R7", abus_tag, 5);
    step(0, 0, 16'h0, 1, 0, 0, 0);
    // R6: completions in reverse issue order
    for (int i = NT - 1; i >= 0; i--) step(0, 0, 16'h0, 1, 1, IW'(i), DW'(16'hc000 + i));
    // R8: tag not in use
    step(0, 0, 16'h0, 1, 1, 3'd2, 16'h0bad);

    // random traffic with out-of-order returns
    for (int n = 0; n < 4000; n++) begin
      nr = 0;
      for (int i = 0; i < NT; i++) begin
        if (m_iss[i]) begin
          if (t_cnt[i] > 0) t_cnt[i]--;
          else begin ready_list[nr] = i; nr++; end
        end
      end
      if ($urandom_range(0, 24) == 0) begin
        pick = $urandom_range(0, NT - 1);
        step($urandom_range(0, 9) < 6, $urandom_range(0, 1), AW'($urandom), $urandom_range(0, 9) < 7,
             !m_iss[pick], IW'(pick), DW'($urandom));
      end else if (nr > 0 && $urandom_range(0, 9) < 7) begin
        pick = ready_list[$urandom_range(0, nr - 1)];
        step($urandom_range(0, 9) < 6, $urandom_range(0, 1), AW'($urandom), $urandom_range(0, 9) < 7,
             1, IW'(pick), DW'($urandom));
      end else begin
        step($urandom_range(0, 9) < 6, $urandom_range(0, 1), AW'($urandom), $urandom_range(0, 9) < 7,
             0, 0, 0);
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule